// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block holds the clock and gate selections for every channel of a ring of three-channel counter chips, arranged as pairs. Software writes one byte at a time to a small window of addresses. There is one clock-select and one gate-select address per chip pair. The byte names the chip within the pair, the channel within the chip, and a 3-bit source code. The selections cannot be read back.

From the stored codes the block builds, for each channel, a clock-enable pulse and a gate level. The sources are the channel's own pins, a pin shared by the chip, five divided timebase ticks, and the outputs of neighbouring channels. For the neighbour sources, the channels are numbered flat across the ring, with chip c channel n at index 3c+n, and the highest chip precedes the lowest. A clock cascade takes the channel one place back. A gate cascade takes the inverted output of the channel two places back.

When a channel's own clock or gate pin is not selected as a source, the block marks that pin as an output and drives the routed signal onto it.

Top module: `ctr_src_router`

## Requirements
- R1: After reset every channel holds clock code 0 and gate code 0. Every gate is high, every clock pin output-enable is low, and every gate pin output-enable is high.
- R2: A write with `wr_en` high updates exactly one channel, starting from the next clock edge. Clock selects live at addresses CLK_BASE+g and gate selects at CLK_BASE+NUM_PAIRS+g, for pair g. Data bit 5 chooses the chip in the pair (chip 2g+bit5). Bits 4:3 choose the channel, and bits 2:0 are the code. A write is ignored if the channel field is 3, if the address lies outside the window, or if `wr_en` is low.
- R3: The clock codes select these levels: 0 is the channel's own clock pin input, 1 to 5 are `tb_tick[0]` to `tb_tick[4]`, and 7 is the chip's shared clock input `shared_clk_in[c]`.
- R4: Clock code 6 selects `ctr_out` of flat index (i-1) mod NCH. This is the previous channel of the same chip, or channel 2 of the preceding chip in the ring.
- R5: Gate code 0 gives a constant high gate, code 1 a constant low gate, and code 2 the channel's own gate pin input.
- R6: Gate code 3 gives the inverse of `ctr_out` at flat index (i-2) mod NCH.
- R7: Gate codes 4 to 7 are stored and give a low gate.
- R8: `clk_en[i]` is high during the cycle in which the selected clock level is first seen high, and it never lasts two cycles. A level that is already high when reset is released gives no pulse.
- R9: `clk_pin_oe[i]` is high exactly when the clock code is not 0, and `clk_pin_out[i]` carries the selected clock level. `gate_pin_oe[i]` is high exactly when the gate code is not 2, and `gate_pin_out[i]` carries the gate.
- R10: The clock and gate selections of a channel are stored independently. A write to one leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Select byte: chip bit 5, channel bits 4:3, code bits 2:0 |
| tb_tick | input | 5 | Timebase ticks, fastest at bit 0 |
| ext_clk_in | input | NCH | Per-channel clock pin inputs |
| shared_clk_in | input | NCHIP | Per-chip shared clock inputs |
| ext_gate_in | input | NCH | Per-channel gate pin inputs |
| ctr_out | input | NCH | Counter channel outputs |
| clk_en | output | NCH | Routed clock-enable pulses |
| gate | output | NCH | Routed gate levels |
| clk_pin_oe | output | NCH | Clock pin output-enables |
| clk_pin_out | output | NCH | Value driven on clock pins |
| gate_pin_oe | output | NCH | Gate pin output-enables |
| gate_pin_out | output | NCH | Value driven on gate pins |

## Verification
The bench builds the router with NUM_PAIRS=2, which gives four chips and twelve channels, with the gate window starting at 26. Each of the twelve channels is swept through all eight clock codes and all eight gate codes, with the selected source driven both low and high. Because the ring is only twelve channels long, the wrap paths can be exercised directly: channel 0 cascading from channel 11, and channels 0 and 1 gating from channels 10 and 11. The smaller ring also keeps the edges of the address window, and the chip-bit decode of the second pair, close at hand.

// File: rtl/ctr_src_router.sv
module ctr_src_router #(
  parameter int NUM_PAIRS = 3,
  parameter int ADDR_W    = 5,
  parameter int CLK_BASE  = 24,
  localparam int NCHIP    = 2 * NUM_PAIRS,
  localparam int NCH      = 3 * NCHIP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [4:0]        tb_tick,
  input  logic [NCH-1:0]    ext_clk_in,
  input  logic [NCHIP-1:0]  shared_clk_in,
  input  logic [NCH-1:0]    ext_gate_in,
  input  logic [NCH-1:0]    ctr_out,
  output logic [NCH-1:0]    clk_en,
  output logic [NCH-1:0]    gate,
  output logic [NCH-1:0]    clk_pin_oe,
  output logic [NCH-1:0]    clk_pin_out,
  output logic [NCH-1:0]    gate_pin_oe,
  output logic [NCH-1:0]    gate_pin_out
);
  localparam logic [ADDR_W-1:0] CB = ADDR_W'(CLK_BASE);
  localparam logic [ADDR_W-1:0] GB = ADDR_W'(CLK_BASE + NUM_PAIRS);
  localparam logic [ADDR_W-1:0] GE = ADDR_W'(CLK_BASE + 2 * NUM_PAIRS);

  logic [NCH-1:0][2:0] clk_code, gate_code;
  logic [NCH-1:0]      clk_wr, gate_wr, sel_lvl, lvl_q;

  wire clk_hit  = wr_en && wr_addr >= CB && wr_addr < GB;
  wire gate_hit = wr_en && wr_addr >= GB && wr_addr < GE;
  wire [ADDR_W-1:0] clk_grp  = wr_addr - CB;
  wire [ADDR_W-1:0] gate_grp = wr_addr - GB;

  function automatic logic pick_clk(input logic [2:0] code, input logic own,
                                    input logic [4:0] tick, input logic prev,
                                    input logic shared);
    case (code)
      3'd0: return own;
      3'd1: return tick[0];
      3'd2: return tick[1];
      3'd3: return tick[2];
      3'd4: return tick[3];
      3'd5: return tick[4];
      3'd6: return prev;
      default: return shared;
    endcase
  endfunction

  function automatic logic pick_gate(input logic [2:0] code, input logic own,
                                     input logic back2);
    case (code)
      3'd0: return 1'b1;
      3'd1: return 1'b0;
      3'd2: return own;
      3'd3: return ~back2;
      default: return 1'b0;
    endcase
  endfunction

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int GRP   = i / 6;
    localparam int CHIP  = i / 3;
    localparam int HALF  = CHIP % 2;
    localparam int N     = i % 3;
    localparam int PREV1 = (i + NCH - 1) % NCH;
    localparam int PREV2 = (i + NCH - 2) % NCH;

    wire tgt = wr_data[5] == 1'(HALF) && wr_data[4:3] == 2'(N);
    assign clk_wr[i]  = clk_hit  && clk_grp  == ADDR_W'(GRP) && tgt;
    assign gate_wr[i] = gate_hit && gate_grp == ADDR_W'(GRP) && tgt;

    assign sel_lvl[i] = pick_clk(clk_code[i], ext_clk_in[i], tb_tick,
                                 ctr_out[PREV1], shared_clk_in[CHIP]);
    assign gate[i]    = pick_gate(gate_code[i], ext_gate_in[i], ctr_out[PREV2]);

    assign clk_pin_oe[i]  = clk_code[i] != 3'd0;
    assign gate_pin_oe[i] = gate_code[i] != 3'd2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_code  <= '0;
      gate_code <= '0;
      lvl_q     <= '1;
    end else begin
      lvl_q <= sel_lvl;
      for (int i = 0; i < NCH; i++) begin
        if (clk_wr[i])  clk_code[i]  <= wr_data[2:0];
        if (gate_wr[i]) gate_code[i] <= wr_data[2:0];
      end
    end
  end

  assign clk_en       = sel_lvl & ~lvl_q;
  assign clk_pin_out  = sel_lvl;
  assign gate_pin_out = gate;
endmodule

// File: rtl/ctr_src_router_chk.sv
module ctr_src_router_chk #(
  parameter int NCH = 18
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [NCH-1:0] ext_clk_in,
  input logic [NCH-1:0] ext_gate_in,
  input logic [NCH-1:0] clk_en,
  input logic [NCH-1:0] gate,
  input logic [NCH-1:0] clk_pin_oe,
  input logic [NCH-1:0] clk_pin_out,
  input logic [NCH-1:0] gate_pin_oe
);
  // R8
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en & $past(clk_en)) == '0);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (clk_pin_oe == '0 && gate_pin_oe == '1 && gate == '1));

  // R2
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> ($stable(clk_pin_oe) && $stable(gate_pin_oe)));

  // R3
  own_clk_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~clk_pin_oe & (clk_pin_out ^ ext_clk_in)) == '0);

  // R5
  own_gate_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~gate_pin_oe & (gate ^ ext_gate_in)) == '0);
endmodule

bind ctr_src_router ctr_src_router_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ext_clk_in(ext_clk_in),
  .ext_gate_in(ext_gate_in), .clk_en(clk_en), .gate(gate),
  .clk_pin_oe(clk_pin_oe), .clk_pin_out(clk_pin_out), .gate_pin_oe(gate_pin_oe)
);

// File: tb/test_ctr_src_router.sv
module test_ctr_src_router;
  localparam int NP    = 2;
  localparam int NCHIP = 2 * NP;
  localparam int N     = 3 * NCHIP;
  localparam int CB    = 24;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [4:0] tb_tick = '0;
  logic [N-1:0] ext_clk_in = '0, ext_gate_in = '0, ctr_out = '0;
  logic [NCHIP-1:0] shared_clk_in = '0;
  logic [N-1:0] clk_en, gate, clk_pin_oe, clk_pin_out, gate_pin_oe, gate_pin_out;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  ctr_src_router #(.NUM_PAIRS(NP), .ADDR_W(5), .CLK_BASE(CB)) i_ctr_src_router (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tb_tick(tb_tick), .ext_clk_in(ext_clk_in), .shared_clk_in(shared_clk_in),
    .ext_gate_in(ext_gate_in), .ctr_out(ctr_out), .clk_en(clk_en), .gate(gate),
    .clk_pin_oe(clk_pin_oe), .clk_pin_out(clk_pin_out),
    .gate_pin_oe(gate_pin_oe), .gate_pin_out(gate_pin_out));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1; wr_addr = 5'(addr); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic int sel_byte(input int i, input int code);
    return (((i / 3) % 2) << 5) | ((i % 3) << 3) | code;
  endfunction

  task automatic set_clk(input int i, input int code);
    wr(CB + (i / 6), sel_byte(i, code));
  endtask

  task automatic set_gate(input int i, input int code);
    wr(CB + NP + (i / 6), sel_byte(i, code));
  endtask

  task automatic quiet();
    tb_tick = '0; ext_clk_in = '0; shared_clk_in = '0; ctr_out = '0; ext_gate_in = '0;
  endtask

  task automatic drive_clk_src(input int i, input int code);
    case (code)
      0: ext_clk_in[i] = 1'b1;
      1, 2, 3, 4, 5: tb_tick[code-1] = 1'b1;
      6: ctr_out[(i + N - 1) % N] = 1'b1;
      default: shared_clk_in[i / 3] = 1'b1;
    endcase
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    ext_clk_in = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 gate", 32'(gate), 32'(N'('1)));
    chk("R1 clk_pin_oe", 32'(clk_pin_oe), 0);
    chk("R1 gate_pin_oe", 32'(gate_pin_oe), 32'(N'('1)));
    chk("R8 no pulse after reset", 32'(clk_en), 0);
    @(negedge clk);
    chk("R8 no pulse held level", 32'(clk_en), 0);
    quiet();

    for (int i = 0; i < N; i++) begin
      for (int code = 0; code < 8; code++) begin
        quiet();
        set_clk(i, code);
        @(negedge clk);
        chk($sformatf("R9 clk oe ch%0d code%0d", i, code), 32'(clk_pin_oe[i]), 32'(code != 0));
        chk($sformatf("R3 idle ch%0d code%0d", i, code), 32'(clk_en[i]), 0);
        drive_clk_src(i, code);
        #1;
        chk($sformatf("%s pulse ch%0d code%0d", code == 6 ? "R4" : "R3", i, code),
            32'(clk_en[i]), 1);
        chk($sformatf("R9 clk pin out ch%0d code%0d", i, code), 32'(clk_pin_out[i]), 1);
        @(negedge clk);
        chk($sformatf("R8 single pulse ch%0d code%0d", i, code), 32'(clk_en[i]), 0);
      end
      quiet();
      set_clk(i, 0);
    end

    for (int i = 0; i < N; i++) begin
      for (int code = 0; code < 8; code++) begin
        set_gate(i, code);
        for (int v = 0; v < 2; v++) begin
          logic e;
          ext_gate_in[i] = 1'(v);
          ctr_out[(i + N - 2) % N] = 1'(v);
          #1;
          case (code)
            0: e = 1'b1;
            1: e = 1'b0;
            2: e = 1'(v);
            3: e = ~1'(v);
            default: e = 1'b0;
          endcase
          chk($sformatf("%s gate ch%0d code%0d v%0d",
              code < 3 ? "R5" : (code == 3 ? "R6" : "R7"), i, code, v), 32'(gate[i]), 32'(e));
          chk($sformatf("R9 gate pin ch%0d code%0d", i, code), 32'(gate_pin_out[i]), 32'(e));
          chk($sformatf("R9 gate oe ch%0d code%0d", i, code), 32'(gate_pin_oe[i]), 32'(code != 2));
          @(negedge clk);
        end
      end
      set_gate(i, 0);
      quiet();
    end

    wr(CB, (3 << 3) | 1);
    wr(CB + NP, (3 << 3) | 1);
    chk("R2 channel field 3 ignored gate", 32'(gate), 32'(N'('1)));
    chk("R2 channel field 3 ignored clk", 32'(clk_pin_oe), 0);
    wr(CB - 1, 1);
    wr(CB + 2 * NP, 1);
    chk("R2 outside window gate", 32'(gate), 32'(N'('1)));
    chk("R2 outside window clk", 32'(clk_pin_oe), 0);
    @(negedge clk);
    wr_addr = 5'(CB + NP); wr_data = 8'(sel_byte(0, 1));
    @(negedge clk);
    chk("R2 write without strobe", 32'(gate), 32'(N'('1)));

    set_gate(7, 1);
    chk("R2 single channel gate", 32'(gate), 32'(N'('1) & ~(N'(1) << 7)));
    chk("R10 gate write leaves clock", 32'(clk_pin_oe), 0);
    set_clk(7, 5);
    chk("R10 clock write leaves gate", 32'(gate), 32'(N'('1) & ~(N'(1) << 7)));
    chk("R2 single channel clock", 32'(clk_pin_oe), 32'(N'(1) << 7));
    set_gate(7, 0);
    chk("R10 gate restore keeps clock", 32'(clk_pin_oe), 32'(N'(1) << 7));

    finish_run();
  end
endmodule